// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This synchronous controller turns a set of supply rails on one after another and turns them off in the opposite order. Each rail has an enable output and two comparator inputs. One input reports that the rail is above its turn-on level. The other reports that it is below its turn-off level. An up/down command chooses the direction of travel.

Two timers are shared by all channels. The step delay timer sets the gap between one channel settling and the next enable changing. The regulation timeout limits how long a newly enabled rail may take to reach its turn-on level. Both timers count ticks of a prescaled clock. Each can be switched off independently. The timer settings are captured once after reset and are never re-read.

If a rail fails to come up in time, the controller raises a fault and walks back down through every rail already enabled. The fault stays latched and refuses new power-up commands. It clears only once the command is withdrawn and every rail reads off.

Top module: `pwrseq_ctrl`

## Requirements
- R1: Timer lengths and timer enables are captured on the first clock edge after reset release. Later changes on those inputs have no effect on any timing until the next reset.
- R2: With up_i high and no fault latched, en_o bits rise in order 0,1,2,3. Before each rise the controller waits one delay period. The first wait starts from the command, and each later wait starts from the cycle in which on_ok_i of the previous channel is seen high.
- R3: A delay period lasts dly_len_i*PRESC_DIV clock cycles, plus one clock of pipeline. With the delay timer disabled, each step takes that single clock.
- R4: The regulation timeout starts when an enable rises, and it is armed only during power-up. If on_ok_i of that channel stays low for reg_len_i*PRESC_DIV+1 clocks, fault_o is set and power-down begins. With the timeout disabled, fault_o never sets.
- R5: Power-down clears enables from the highest set bit down to bit 0. Before each clear the controller waits one delay period. The first wait starts when power-down begins, and each later wait starts once off_ok_i of the channel just cleared reads high.
- R6: pwrgd_o is high only when the full sequence has completed and every on_ok_i bit is high.
- R7: seq_done_o rises one delay period after the last channel reports on. It falls on the first clock of power-down.
- R8: fault_o stays set while up_i is high or any off_ok_i bit is low. While it is set, no enable rises. It clears on the first clock with up_i low and all off_ok_i high in the idle state.
- R9: Dropping up_i part-way through power-up begins power-down at once, starting from the highest enable already set.
- R10: The set enables always form a contiguous run starting at bit 0, and at most one enable changes per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_i | input | 1 | 1 = power up, 0 = power down |
| on_ok_i | input | N_CH | Per-rail flag: rail above its turn-on level |
| off_ok_i | input | N_CH | Per-rail flag: rail below its turn-off level |
| dly_len_i | input | TMR_W | Step delay in prescaled ticks |
| dly_on_i | input | 1 | Step delay timer enabled |
| reg_len_i | input | TMR_W | Regulation timeout in prescaled ticks |
| reg_on_i | input | 1 | Regulation timeout enabled |
| en_o | output | N_CH | Rail enables |
| pwrgd_o | output | 1 | All rails enabled and in regulation |
| seq_done_o | output | 1 | Power-up sequence complete |
| fault_o | output | 1 | Latched regulation timeout fault |

## Verification
The bench builds the controller with PRESC_DIV=4 and TMR_W=8. It uses a 3-tick step delay and a 10-tick regulation timeout. These short settings let a whole power-up, a timeout fault with its walk back down, and an aborted power-up all fit in a few hundred cycles. A second reset reloads the controller with both timers switched off. This exercises one-clock stepping and shows that a rail which never comes up is waited on forever instead of faulting. Timer inputs are changed after each capture so that any re-sampling would shift the cycle counts.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_DLY,
    ST_UP_WAIT,
    ST_ON,
    ST_DN_DLY,
    ST_DN_WAIT
  } seq_st_e;
endpackage

// File: rtl/pwrseq_cfg.sv
module pwrseq_cfg #(
  parameter int unsigned TMR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] dly_len_i,
  input  logic             dly_on_i,
  input  logic [TMR_W-1:0] reg_len_i,
  input  logic             reg_on_i,
  output logic [TMR_W-1:0] dly_len_o,
  output logic             dly_on_o,
  output logic [TMR_W-1:0] reg_len_o,
  output logic             reg_on_o,
  output logic             vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_len_o <= '0;
      dly_on_o  <= 1'b0;
      reg_len_o <= '0;
      reg_on_o  <= 1'b0;
      vld_o     <= 1'b0;
    end else if (!vld_o) begin
      dly_len_o <= dly_len_i;
      dly_on_o  <= dly_on_i;
      reg_len_o <= reg_len_i;
      reg_on_o  <= reg_on_i;
      vld_o     <= 1'b1;
    end
  end

  // R1
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> ($stable(dly_len_o) && $stable(dly_on_o) && $stable(reg_len_o) && $stable(reg_on_o)));
endmodule

// File: rtl/pwrseq_tmr.sv
module pwrseq_tmr #(
  parameter int unsigned TMR_W     = 12,
  parameter int unsigned PRESC_DIV = 500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TMR_W-1:0] len_i,
  output logic             zero_o
);
  localparam int unsigned PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PMAX = PW'(PRESC_DIV - 1);

  logic [TMR_W-1:0] cnt_q;
  logic [PW-1:0]    pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (start_i) begin
      cnt_q <= len_i;
      pre_q <= '0;
    end else if (cnt_q != '0) begin
      if (pre_q == PMAX) begin
        pre_q <= '0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign zero_o = (cnt_q == '0);

  // R3
  tmr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && zero_o) |=> zero_o);
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned TMR_W     = 12,
  parameter int unsigned PRESC_DIV = 500
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic [N_CH-1:0]  on_ok_i,
  input  logic [N_CH-1:0]  off_ok_i,
  input  logic [TMR_W-1:0] dly_len_i,
  input  logic             dly_on_i,
  input  logic [TMR_W-1:0] reg_len_i,
  input  logic             reg_on_i,
  output logic [N_CH-1:0]  en_o,
  output logic             pwrgd_o,
  output logic             seq_done_o,
  output logic             fault_o
);
  localparam int unsigned IW = $clog2(N_CH + 1);
  localparam int unsigned CW = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [IW-1:0] IDX_END  = IW'(N_CH);
  localparam logic [IW-1:0] IDX_LAST = IW'(N_CH - 1);

  seq_st_e          st_q, st_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [N_CH-1:0]  en_q, en_d;
  logic             flt_q, flt_d;
  logic [TMR_W-1:0] dly_len_q, reg_len_q;
  logic             dly_on_q, reg_on_q, cfg_vld;
  logic             dly_zero, reg_zero, dly_start, reg_start, dly_go;
  logic [CW-1:0]    ch;

  pwrseq_cfg #(.TMR_W(TMR_W)) u_cfg (
    .clk_i, .rst_ni,
    .dly_len_i, .dly_on_i, .reg_len_i, .reg_on_i,
    .dly_len_o(dly_len_q), .dly_on_o(dly_on_q),
    .reg_len_o(reg_len_q), .reg_on_o(reg_on_q),
    .vld_o(cfg_vld)
  );

  pwrseq_tmr #(.TMR_W(TMR_W), .PRESC_DIV(PRESC_DIV)) u_dly_tmr (
    .clk_i, .rst_ni, .start_i(dly_start), .len_i(dly_len_q), .zero_o(dly_zero)
  );

  pwrseq_tmr #(.TMR_W(TMR_W), .PRESC_DIV(PRESC_DIV)) u_reg_tmr (
    .clk_i, .rst_ni, .start_i(reg_start), .len_i(reg_len_q), .zero_o(reg_zero)
  );

  assign ch     = idx_q[CW-1:0];
  assign dly_go = !dly_on_q || dly_zero;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    en_d  = en_q;
    flt_d = flt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (flt_q) begin
          if (!up_i && (&off_ok_i)) flt_d = 1'b0;
        end else if (cfg_vld && up_i) begin
          st_d  = ST_UP_DLY;
          idx_d = '0;
        end
      end
      ST_UP_DLY: begin
        if (!up_i) begin
          // abort: walk back from the highest enable already set
          if (idx_q == '0) st_d = ST_IDLE;
          else begin
            idx_d = idx_q - 1'b1;
            st_d  = ST_DN_DLY;
          end
        end else if (dly_go) begin
          if (idx_q == IDX_END) st_d = ST_ON;
          else begin
            en_d[ch] = 1'b1;
            st_d     = ST_UP_WAIT;
          end
        end
      end
      ST_UP_WAIT: begin
        if (!up_i) st_d = ST_DN_DLY;
        else if (on_ok_i[ch]) begin
          idx_d = idx_q + 1'b1;
          st_d  = ST_UP_DLY;
        end else if (reg_on_q && reg_zero) begin
          flt_d = 1'b1;
          st_d  = ST_DN_DLY;
        end
      end
      ST_ON: begin
        if (!up_i) begin
          idx_d = IDX_LAST;
          st_d  = ST_DN_DLY;
        end
      end
      ST_DN_DLY: begin
        if (dly_go) begin
          en_d[ch] = 1'b0;
          st_d     = ST_DN_WAIT;
        end
      end
      ST_DN_WAIT: begin
        if (off_ok_i[ch]) begin
          if (idx_q == '0) st_d = ST_IDLE;
          else begin
            idx_d = idx_q - 1'b1;
            st_d  = ST_DN_DLY;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign dly_start = (st_d != st_q) && ((st_d == ST_UP_DLY) || (st_d == ST_DN_DLY));
  assign reg_start = (st_d == ST_UP_WAIT) && (st_q != ST_UP_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      en_q  <= '0;
      flt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      en_q  <= en_d;
      flt_q <= flt_d;
    end
  end

  assign en_o       = en_q;
  assign fault_o    = flt_q;
  assign seq_done_o = (st_q == ST_ON);
  assign pwrgd_o    = (st_q == ST_ON) && (&on_ok_i);

  // R10
  en_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_o + 1'b1) & en_o) == '0);
  // R10
  en_one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(en_o ^ $past(en_o)) <= 1);
  // R6
  pwrgd_all_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwrgd_o |-> ((&en_o) && seq_done_o));
  // R7
  done_all_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> (&en_o));
  // R8
  flt_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> ((en_o & ~$past(en_o)) == '0));
  // R4
  reg_off_no_flt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_on_q && !$past(fault_o)) |-> !fault_o);
endmodule

// File: tb/sim_pwrseq_ctrl.sv
`timescale 1ns/1ps
module sim_pwrseq_ctrl;
  localparam int N = 4, W = 8, DIV = 4, RAMP = 6;

  logic clk = 1'b0, rst_n = 1'b0, up = 1'b0;
  logic [N-1:0] rail = '0, stuck = '0;
  logic [W-1:0] dly_len = 8'd3, reg_len = 8'd10;
  logic dly_on = 1'b1, reg_on = 1'b1;
  logic [N-1:0] en;
  logic pwrgd, done, flt;
  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  pwrseq_ctrl #(.N_CH(N), .TMR_W(W), .PRESC_DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .on_ok_i(rail), .off_ok_i(~rail),
    .dly_len_i(dly_len), .dly_on_i(dly_on), .reg_len_i(reg_len), .reg_on_i(reg_on),
    .en_o(en), .pwrgd_o(pwrgd), .seq_done_o(done), .fault_o(flt)
  );

  // reference model: 0 idle,1 up delay,2 up wait,3 on,4 down delay,5 down wait
  int m_st, m_idx, m_dr, m_rr, m_dc, m_rc;
  bit m_de, m_re, m_cv, m_flt;
  logic [N-1:0] m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_en = '0; m_flt = 0; m_cv = 0; m_dr = 0; m_rr = 0;
    end else if (!m_cv) begin
      m_dc = dly_len; m_de = dly_on; m_rc = reg_len; m_re = reg_on; m_cv = 1;
    end else begin
      case (m_st)
        0: if (m_flt) begin
             if (!up && rail == '0) m_flt = 0;
           end else if (up) begin m_st = 1; m_idx = 0; m_dr = m_dc * DIV; end
        1: if (!up) begin
             if (m_idx == 0) m_st = 0;
             else begin m_idx--; m_st = 4; m_dr = m_dc * DIV; end
           end else if (!m_de || m_dr == 0) begin
             if (m_idx == N) m_st = 3;
             else begin m_en[m_idx] = 1; m_st = 2; m_rr = m_rc * DIV; end
           end else m_dr--;
        2: if (!up) begin m_st = 4; m_dr = m_dc * DIV; end
           else if (rail[m_idx]) begin m_idx++; m_st = 1; m_dr = m_dc * DIV; end
           else if (m_re && m_rr == 0) begin m_flt = 1; m_st = 4; m_dr = m_dc * DIV; end
           else if (m_rr > 0) m_rr--;
        3: if (!up) begin m_idx = N - 1; m_st = 4; m_dr = m_dc * DIV; end
        4: if (!m_de || m_dr == 0) begin m_en[m_idx] = 0; m_st = 5; end
           else m_dr--;
        5: if (!rail[m_idx]) begin
             if (m_idx == 0) m_st = 0;
             else begin m_idx--; m_st = 4; m_dr = m_dc * DIV; end
           end
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-cycle compare, then rail plant update
  int ramp [N];
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(en == m_en, "R2 R5 R9 R10 en_o", en, m_en);
      chk(flt == m_flt, "R4 R8 fault_o", flt, m_flt);
      chk(done == (m_st == 3), "R7 seq_done_o", done, m_st == 3);
      chk(pwrgd == (m_st == 3 && rail == '1), "R6 pwrgd_o", pwrgd, m_st == 3 && rail == '1);
    end
    for (int i = 0; i < N; i++) begin
      if (en[i] != rail[i] && !(en[i] && stuck[i])) begin
        ramp[i]++;
        if (ramp[i] >= RAMP) begin rail[i] = en[i]; ramp[i] = 0; end
      end else ramp[i] = 0;
    end
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cycles(3);
    chk(en == '0 && !flt && !done && !pwrgd, "R1 reset state", {en, flt, done, pwrgd}, 0);
    rst_n = 1'b1;
    cycles(2);
    // R1: alter settings after capture; model keeps captured values
    dly_len = 8'd1; reg_len = 8'd2; dly_on = 1'b0;
    up = 1'b1;
    cycles(160);
    chk(done && pwrgd && en == '1, "R2 R7 full power-up", {en, done, pwrgd}, 'h3f);
    up = 1'b0;
    cycles(140);
    chk(en == '0 && !done, "R5 full power-down", en, 0);
    // R4 fault: channel 2 never reaches regulation
    stuck = 4'b0100;
    up = 1'b1;
    cycles(200);
    chk(flt && en == '0, "R4 fault and walk-down", {flt, en}, 'h10);
    cycles(40);
    chk(en == '0 && flt, "R8 fault blocks new power-up", {flt, en}, 'h10);
    up = 1'b0;
    cycles(3);
    chk(!flt, "R8 fault clears", flt, 0);
    stuck = '0;
    // R9 abort part-way through power-up
    up = 1'b1;
    cycles(45);
    up = 1'b0;
    cycles(120);
    chk(en == '0 && !flt, "R9 abort walk-down", en, 0);
    // R3/R4 second reset: both timers disabled
    @(negedge clk);
    rst_n = 1'b0; dly_on = 1'b0; reg_on = 1'b0; dly_len = 8'd9; reg_len = 8'd1;
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    dly_on = 1'b1; reg_on = 1'b1;
    stuck = 4'b0010;
    up = 1'b1;
    cycles(200);
    chk(!flt && en == 4'b0011, "R4 disabled timeout never faults", {flt, en}, 3);
    stuck = '0;
    cycles(40);
    chk(done && en == '1, "R3 one-clock steps complete", {en, done}, 'h1f);
    up = 1'b0;
    cycles(60);
    chk(en == '0, "R3 R5 power-down no delay", en, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule